// File: doc/BRIEF.md
# Serial Port Auto-Powerdown Controller

This block is the digital power manager for a bank of serial line transceivers. Each receiver line reports a flag that says whether it currently carries a valid signalling level. The flags arrive already digitized and synchronized to `clk`. From these flags, a force-on input, an active-low force-off input and an active-low receiver enable, the block decides when to run the charge pump and when to drive the transmitters. It also decides which receiver outputs are enabled and whether to report that the link is dead.

There are three power states. In OFF the pump and the transmitters are off. In WAKING the pump runs while the supplies recover. In ACTIVE the transmitters drive. With neither force input asserted, the block sleeps on its own after a quiet period and wakes on the first valid level on any line. A wake that is not followed by more valid levels falls back to OFF after the same quiet period. The active-low `invalid_n` flag is qualified separately and is reported in every mode. All times are given in microseconds and converted to clock ticks through `TICKS_PER_US`.

Top module: `linepwr_ctrl`

## Requirements
- R1: `invalid_n` goes low after FALL_US*TICKS_PER_US consecutive sampled cycles in which every `line_valid` bit is 0. Any cycle with a set bit restarts that count.
- R2: `invalid_n` goes high after RISE_US*TICKS_PER_US consecutive sampled cycles in which at least one `line_valid` bit is 1. A cycle with no set bit restarts that count, so a shorter pulse leaves `invalid_n` low.
- R3: `invalid_n` depends only on `line_valid` and reset. The force inputs, the receiver enable and the power state do not change it.
- R4: While `force_off_n` is 0, `status` is OFF from the next clock edge onward, with `pump_en` = 0 and all `tx_oe` bits 0. This holds whatever `force_on` and `line_valid` are.
- R5: With `force_off_n` = 1 and `force_on` = 1, the block leaves OFF at the next edge and never powers down on its own.
- R6: In automatic mode (`force_on` = 0, `force_off_n` = 1), an OFF block moves to WAKING at the edge that samples any set `line_valid` bit.
- R7: The `status` codes are OFF = 0, WAKING = 1 and ACTIVE = 2. WAKING lasts WAKE_US*TICKS_PER_US cycles and then becomes ACTIVE. `pump_en` is 1 in WAKING and ACTIVE. `tx_oe` bits are 1 only in ACTIVE.
- R8: In automatic mode a powered block returns to OFF after SLEEP_US*TICKS_PER_US consecutive cycles with no valid line. The count starts at power-up or at the last valid sample, which covers the fall-back after a false wake.
- R9: Each `std_rx_oe` bit is 1 exactly when `rx_en_n` = 0 and `force_off_n` = 1. Automatic powerdown does not clear it.
- R10: Every `mon_rx_oe` bit is 1 in all modes and states.
- R11: Synchronous reset puts the block in OFF with `invalid_n` = 0, `pump_en` = 0 and all `tx_oe` bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_valid | input | NUM_LINES | Per-line valid-level flag, synchronized |
| force_on | input | 1 | Keep powered, disables automatic sleep |
| force_off_n | input | 1 | Active-low forced powerdown, highest priority |
| rx_en_n | input | 1 | Active-low enable for standard receivers |
| invalid_n | output | 1 | Low when all lines have been invalid for the qualification time |
| pump_en | output | 1 | Charge-pump enable |
| tx_oe | output | NUM_TX | Transmitter output enables |
| std_rx_oe | output | NUM_STD_RX | Standard receiver output enables |
| mon_rx_oe | output | NUM_MON_RX | Monitor receiver output enables |
| status | output | 2 | Power state: 0 OFF, 1 WAKING, 2 ACTIVE |

## Verification
The bench builds the block with TICKS_PER_US = 4. This gives a 120-cycle invalid and sleep window, a 4-cycle valid filter and a 400-cycle recovery. At these lengths, random segments of up to 150 cycles often cross every timer boundary, and the directed runs can count each window to the exact edge. It uses four lines, two transmitters, three standard and two monitor receivers, so the vector enables are also checked at widths above one.

// File: rtl/linepwr_pkg.sv
package linepwr_pkg;

    typedef enum logic [1:0] {
        PWR_OFF    = 2'd0,
        PWR_WAKING = 2'd1,
        PWR_ACTIVE = 2'd2
    } pwr_state_e;

    typedef struct packed {
        logic forced_off;
        logic forced_on;
        logic auto_mode;
    } ctl_mode_t;

    function automatic int us_to_ticks(input int us, input int tpu);
        return (us * tpu < 1) ? 1 : us * tpu;
    endfunction

    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic ctl_mode_t decode_mode(input logic force_on, input logic force_off_n);
        ctl_mode_t m;
        m.forced_off = ~force_off_n;
        m.forced_on  = force_off_n & force_on;
        m.auto_mode  = force_off_n & ~force_on;
        return m;
    endfunction

endpackage

// File: rtl/linepwr_qualifier.sv
module linepwr_qualifier
    import linepwr_pkg::*;
#(
    parameter int NUM_LINES  = 5,
    parameter int FALL_TICKS = 480,
    parameter int RISE_TICKS = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] line_valid,
    output logic                 invalid_n
);
    localparam int FW = cnt_width(FALL_TICKS);
    localparam int RW = cnt_width(RISE_TICKS);
    localparam logic [FW-1:0] FALL_LAST = FW'(FALL_TICKS - 1);
    localparam logic [RW-1:0] RISE_LAST = RW'(RISE_TICKS - 1);

    logic          any_valid;
    logic [FW-1:0] fall_cnt;
    logic [RW-1:0] rise_cnt;

    assign any_valid = |line_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            invalid_n <= 1'b0;
            fall_cnt  <= '0;
            rise_cnt  <= '0;
        end else if (any_valid) begin
            fall_cnt <= '0;
            if (!invalid_n) begin
                if (rise_cnt == RISE_LAST) begin
                    invalid_n <= 1'b1;
                    rise_cnt  <= '0;
                end else begin
                    rise_cnt <= rise_cnt + 1'b1;
                end
            end
        end else begin
            rise_cnt <= '0;
            if (invalid_n) begin
                if (fall_cnt == FALL_LAST) begin
                    invalid_n <= 1'b0;
                    fall_cnt  <= '0;
                end else begin
                    fall_cnt <= fall_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/linepwr_power_fsm.sv
module linepwr_power_fsm
    import linepwr_pkg::*;
#(
    parameter int WAKE_TICKS  = 1600,
    parameter int SLEEP_TICKS = 480
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       any_valid,
    input  ctl_mode_t  mode,
    output pwr_state_e state
);
    localparam int WW = cnt_width(WAKE_TICKS);
    localparam int SW = cnt_width(SLEEP_TICKS);
    localparam logic [WW-1:0] WAKE_LAST  = WW'(WAKE_TICKS - 1);
    localparam logic [SW-1:0] SLEEP_LAST = SW'(SLEEP_TICKS - 1);

    logic [WW-1:0] wake_cnt;
    logic [SW-1:0] idle_cnt;
    logic          idle_done;
    logic          go_sleep;
    logic [SW-1:0] idle_next;

    assign idle_done = !any_valid && (idle_cnt == SLEEP_LAST);
    assign go_sleep  = mode.auto_mode && idle_done;

    always_comb begin
        if (any_valid)
            idle_next = '0;
        else if (idle_cnt != SLEEP_LAST)
            idle_next = idle_cnt + 1'b1;
        else
            idle_next = idle_cnt;
    end

    always_ff @(posedge clk) begin
        if (rst || mode.forced_off) begin
            state    <= PWR_OFF;
            wake_cnt <= '0;
            idle_cnt <= '0;
        end else begin
            unique case (state)
                PWR_OFF: begin
                    wake_cnt <= '0;
                    idle_cnt <= '0;
                    if (mode.forced_on || any_valid)
                        state <= PWR_WAKING;
                end
                PWR_WAKING: begin
                    if (go_sleep) begin
                        state    <= PWR_OFF;
                        wake_cnt <= '0;
                        idle_cnt <= '0;
                    end else begin
                        idle_cnt <= idle_next;
                        if (wake_cnt == WAKE_LAST) begin
                            state    <= PWR_ACTIVE;
                            wake_cnt <= '0;
                        end else begin
                            wake_cnt <= wake_cnt + 1'b1;
                        end
                    end
                end
                PWR_ACTIVE: begin
                    if (go_sleep) begin
                        state    <= PWR_OFF;
                        idle_cnt <= '0;
                    end else begin
                        idle_cnt <= idle_next;
                    end
                end
                default: begin
                    state    <= PWR_OFF;
                    wake_cnt <= '0;
                    idle_cnt <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/linepwr_oe_decode.sv
module linepwr_oe_decode
    import linepwr_pkg::*;
#(
    parameter int NUM_TX     = 3,
    parameter int NUM_STD_RX = 5,
    parameter int NUM_MON_RX = 2
) (
    input  pwr_state_e            state,
    input  ctl_mode_t             mode,
    input  logic                  rx_en_n,
    output logic                  pump_en,
    output logic [NUM_TX-1:0]     tx_oe,
    output logic [NUM_STD_RX-1:0] std_rx_oe,
    output logic [NUM_MON_RX-1:0] mon_rx_oe
);
    logic tx_on;
    logic std_on;

    assign pump_en = (state != PWR_OFF);
    assign tx_on   = (state == PWR_ACTIVE);
    assign std_on  = !rx_en_n && !mode.forced_off;

    for (genvar t = 0; t < NUM_TX; t++) begin : g_tx
        assign tx_oe[t] = tx_on;
    end

    for (genvar s = 0; s < NUM_STD_RX; s++) begin : g_std
        assign std_rx_oe[s] = std_on;
    end

    for (genvar m = 0; m < NUM_MON_RX; m++) begin : g_mon
        assign mon_rx_oe[m] = 1'b1;
    end

endmodule

// File: rtl/linepwr_ctrl.sv
module linepwr_ctrl
    import linepwr_pkg::*;
#(
    parameter int NUM_LINES    = 5,
    parameter int NUM_TX       = 3,
    parameter int NUM_STD_RX   = 5,
    parameter int NUM_MON_RX   = 2,
    parameter int TICKS_PER_US = 16,
    parameter int FALL_US      = 30,
    parameter int RISE_US      = 1,
    parameter int WAKE_US      = 100,
    parameter int SLEEP_US     = 30
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_LINES-1:0]  line_valid,
    input  logic                  force_on,
    input  logic                  force_off_n,
    input  logic                  rx_en_n,
    output logic                  invalid_n,
    output logic                  pump_en,
    output logic [NUM_TX-1:0]     tx_oe,
    output logic [NUM_STD_RX-1:0] std_rx_oe,
    output logic [NUM_MON_RX-1:0] mon_rx_oe,
    output logic [1:0]            status
);
    localparam int FALL_TICKS  = us_to_ticks(FALL_US,  TICKS_PER_US);
    localparam int RISE_TICKS  = us_to_ticks(RISE_US,  TICKS_PER_US);
    localparam int WAKE_TICKS  = us_to_ticks(WAKE_US,  TICKS_PER_US);
    localparam int SLEEP_TICKS = us_to_ticks(SLEEP_US, TICKS_PER_US);

    ctl_mode_t  mode;
    pwr_state_e state;

    assign mode   = decode_mode(force_on, force_off_n);
    assign status = state;

    linepwr_qualifier #(
        .NUM_LINES (NUM_LINES),
        .FALL_TICKS(FALL_TICKS),
        .RISE_TICKS(RISE_TICKS)
    ) u_qual (
        .clk       (clk),
        .rst       (rst),
        .line_valid(line_valid),
        .invalid_n (invalid_n)
    );

    linepwr_power_fsm #(
        .WAKE_TICKS (WAKE_TICKS),
        .SLEEP_TICKS(SLEEP_TICKS)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .any_valid(|line_valid),
        .mode     (mode),
        .state    (state)
    );

    linepwr_oe_decode #(
        .NUM_TX    (NUM_TX),
        .NUM_STD_RX(NUM_STD_RX),
        .NUM_MON_RX(NUM_MON_RX)
    ) u_oe (
        .state    (state),
        .mode     (mode),
        .rx_en_n  (rx_en_n),
        .pump_en  (pump_en),
        .tx_oe    (tx_oe),
        .std_rx_oe(std_rx_oe),
        .mon_rx_oe(mon_rx_oe)
    );

endmodule

// File: rtl/linepwr_checker.sv
module linepwr_checker #(
    parameter int NUM_LINES  = 5,
    parameter int NUM_TX     = 3,
    parameter int NUM_STD_RX = 5
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NUM_LINES-1:0]  line_valid,
    input logic                  force_on,
    input logic                  force_off_n,
    input logic                  invalid_n,
    input logic                  pump_en,
    input logic [NUM_TX-1:0]     tx_oe,
    input logic [NUM_STD_RX-1:0] std_rx_oe,
    input logic [1:0]            status
);
    a_r1_fall_needs_quiet: assert property (@(posedge clk) disable iff (rst)
        $fell(invalid_n) |-> !$past(|line_valid));

    a_r2_rise_needs_valid: assert property (@(posedge clk) disable iff (rst)
        $rose(invalid_n) |-> $past(|line_valid));

    a_r4_force_off_wins: assert property (@(posedge clk) disable iff (rst)
        !force_off_n |=> (status == 2'd0 && !pump_en && tx_oe == '0));

    a_r5_forced_on_holds: assert property (@(posedge clk) disable iff (rst)
        (force_off_n && force_on && status != 2'd0) |=> status != 2'd0);

    a_r6_auto_wake: assert property (@(posedge clk) disable iff (rst)
        (force_off_n && status == 2'd0 && |line_valid) |=> status == 2'd1);

    a_r7_tx_after_waking: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_oe[0]) |-> $past(status) == 2'd1);

    a_r8_valid_keeps_power: assert property (@(posedge clk) disable iff (rst)
        (force_off_n && status != 2'd0 && |line_valid) |=> status != 2'd0);

    a_r9_std_off_when_forced: assert property (@(posedge clk) disable iff (rst)
        !force_off_n |-> std_rx_oe == '0);

endmodule

bind linepwr_ctrl linepwr_checker #(
    .NUM_LINES (NUM_LINES),
    .NUM_TX    (NUM_TX),
    .NUM_STD_RX(NUM_STD_RX)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .line_valid (line_valid),
    .force_on   (force_on),
    .force_off_n(force_off_n),
    .invalid_n  (invalid_n),
    .pump_en    (pump_en),
    .tx_oe      (tx_oe),
    .std_rx_oe  (std_rx_oe),
    .status     (status)
);

// File: tb/test_linepwr_ctrl.sv
`timescale 1ns/1ps
module test_linepwr_ctrl;
    localparam int NL = 4, NT = 2, NS = 3, NM = 2, TPU = 4;
    localparam int FALL = 30 * TPU, RISE = 1 * TPU, WAKE = 100 * TPU, SLEEP = 30 * TPU;

    logic clk = 1'b0;
    logic rst;
    logic [NL-1:0] lv;
    logic fon, foffn, renn;
    logic invalid_n, pump_en;
    logic [NT-1:0] tx_oe;
    logic [NS-1:0] std_rx_oe;
    logic [NM-1:0] mon_rx_oe;
    logic [1:0] status;

    int checks = 0, failures = 0;
    bit done = 0;

    int m_inv, m_fall, m_rise, m_st, m_wake, m_idle;

    always #5 clk = ~clk;

    linepwr_ctrl #(
        .NUM_LINES(NL), .NUM_TX(NT), .NUM_STD_RX(NS), .NUM_MON_RX(NM),
        .TICKS_PER_US(TPU)
    ) i_linepwr_ctrl (
        .clk(clk), .rst(rst), .line_valid(lv), .force_on(fon),
        .force_off_n(foffn), .rx_en_n(renn), .invalid_n(invalid_n),
        .pump_en(pump_en), .tx_oe(tx_oe), .std_rx_oe(std_rx_oe),
        .mon_rx_oe(mon_rx_oe), .status(status)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit av;
        av = |lv;
        if (rst) begin
            m_inv = 0; m_fall = 0; m_rise = 0; m_st = 0; m_wake = 0; m_idle = 0;
            return;
        end
        if (av) begin
            m_fall = 0;
            if (m_inv == 0) begin
                m_rise++;
                if (m_rise == RISE) begin m_inv = 1; m_rise = 0; end
            end
        end else begin
            m_rise = 0;
            if (m_inv == 1) begin
                m_fall++;
                if (m_fall == FALL) begin m_inv = 0; m_fall = 0; end
            end
        end
        if (!foffn) begin
            m_st = 0; m_wake = 0; m_idle = 0;
        end else if (m_st == 0) begin
            if (fon || av) m_st = 1;
            m_wake = 0; m_idle = 0;
        end else begin
            if (av) m_idle = 0;
            else if (m_idle < SLEEP) m_idle++;
            if (!fon && m_idle >= SLEEP) begin
                m_st = 0; m_wake = 0; m_idle = 0;
            end else if (m_st == 1) begin
                m_wake++;
                if (m_wake == WAKE) begin m_st = 2; m_wake = 0; end
            end
        end
    endtask

    task automatic compare_model();
        check("R1 R2 R3 invalid_n", int'(invalid_n), m_inv);
        check("R7 status", int'(status), m_st);
        check("R7 pump_en", int'(pump_en), int'(m_st != 0));
        check("R7 tx_oe", int'(tx_oe), (m_st == 2) ? (1 << NT) - 1 : 0);
        check("R9 std_rx_oe", int'(std_rx_oe), (!renn && foffn) ? (1 << NS) - 1 : 0);
        check("R10 mon_rx_oe", int'(mon_rx_oe), (1 << NM) - 1);
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_model();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        rst = 1; lv = '0; fon = 0; foffn = 1; renn = 0;
        ticks(3);
        // R11 reset state
        check("R11 status", int'(status), 0);
        check("R11 invalid_n", int'(invalid_n), 0);
        check("R11 pump_en", int'(pump_en), 0);
        check("R11 tx_oe", int'(tx_oe), 0);
        rst = 0;

        // R6 automatic wake, R2 rise filter, R7 recovery length
        lv = 4'b0100;
        tick();
        check("R6 wake status", int'(status), 1);
        ticks(2);
        check("R2 still low", int'(invalid_n), 0);
        tick();
        check("R2 rises after filter", int'(invalid_n), 1);
        ticks(396);
        check("R7 still waking", int'(status), 1);
        check("R7 tx off while waking", int'(tx_oe), 0);
        tick();
        check("R7 active", int'(status), 2);
        check("R7 tx on", int'(tx_oe), 3);

        // R1 and R8 quiet window
        lv = '0;
        ticks(FALL - 1);
        check("R1 still high", int'(invalid_n), 1);
        check("R8 still active", int'(status), 2);
        tick();
        check("R1 falls", int'(invalid_n), 0);
        check("R8 sleeps", int'(status), 0);
        check("R9 std kept in auto sleep", int'(std_rx_oe), 7);

        // R8 false wake returns to OFF, R2 short pulse ignored
        lv = 4'b0001;
        tick();
        check("R6 wake on pulse", int'(status), 1);
        lv = '0;
        ticks(SLEEP - 1);
        check("R2 short pulse ignored", int'(invalid_n), 0);
        check("R8 waking before window", int'(status), 1);
        tick();
        check("R8 resleep", int'(status), 0);

        // R5 forced on, R3 invalid unaffected
        fon = 1;
        tick();
        check("R5 forced wake", int'(status), 1);
        ticks(WAKE);
        check("R5 active", int'(status), 2);
        ticks(300);
        check("R5 no auto sleep", int'(status), 2);
        check("R3 invalid while forced on", int'(invalid_n), 0);

        // R4 forced off overrides, R10 monitor, R3
        foffn = 0; lv = 4'b1111;
        tick();
        check("R4 off", int'(status), 0);
        check("R4 pump off", int'(pump_en), 0);
        check("R9 std off when forced", int'(std_rx_oe), 0);
        check("R10 monitor on", int'(mon_rx_oe), 3);
        ticks(4);
        check("R3 invalid rises while forced off", int'(invalid_n), 1);
        check("R4 stays off", int'(status), 0);
        foffn = 1; fon = 0; renn = 1;
        tick();
        check("R9 std off by enable", int'(std_rx_oe), 0);

        // constrained random segments
        for (int seg = 0; seg < 90; seg++) begin
            int len;
            lv    = ($urandom % 3 == 0) ? NL'(0) : NL'($urandom);
            fon   = ($urandom % 4 == 0);
            foffn = ($urandom % 6 != 0);
            renn  = ($urandom % 3 == 0);
            len   = ($urandom % 4 == 0) ? 1 + $urandom % 6 : 1 + $urandom % 150;
            ticks(len);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule